// File: doc/BRIEF.md
# Wired Interrupt to Message Write Bridge

This block sits between a bank of wired, level-sensitive interrupt lines and an upstream interrupt controller that only understands memory writes. Every line is synchronized and watched for transitions, and each transition that its configuration asks for becomes a single 64-bit-address, 32-bit-data write request. Each line has its own configuration word: an enable, an edge flag, a group code and a 24-bit payload that becomes the message data.

Two groups exist. The paired group reports a line that goes high with a SET write and a line that goes low with a CLEAR write, each to its own programmable 64-bit target. The pulse group reports only rising edges, to a third target. Pending events are kept per line. A round-robin arbiter picks one line at a time, and the chosen request is held on the output until the receiver takes it. Two specific lines, 107 and 109, share one configuration word, so both of them report to the same message target.

Top module: `wire_irq_msg_bridge`

## Requirements
- R1: After reset no request is presented, and every configuration word and target address reads as zero. A line with an all-zero word sends nothing, and an enabled line whose targets were never written sends to address 0.
- R2: The word for line n (0..206) is written at byte offset 0x100+4*n. Bit 24 enables the line, bit 28 is the edge flag, bits 31:29 are the group (0 = paired, 1 = pulse) and bits 23:0 are the payload. The message data is the payload zero-extended to 32 bits.
- R3: The target addresses are written as 32-bit halves. The paired SET target is at 0x10 (low half) and 0x14 (high half). The paired CLEAR target is at 0x18 and 0x1C. The pulse SET target is at 0x50 and 0x54.
- R4: A paired-group line with the edge flag clear sends a SET write to the paired SET target when it rises, and a CLEAR write to the paired CLEAR target when it falls.
- R5: A pulse-group line sends a SET write to the pulse target on a rise and nothing on a fall. A paired-group line with the edge flag set sends a SET write to the paired SET target on a rise and nothing on a fall.
- R6: If a paired line rises and falls again before its SET write is sent, both writes are still sent, SET first and then CLEAR.
- R7: A write that clears the enable bit drops the line's pending events. The line then sends no further message beyond one already on the output.
- R8: One request is presented at a time. After line n is served, the search for the next line starts at n+1 and wraps past the last line.
- R9: While a request is valid and ready is low, the request stays valid and its address and data do not change.
- R10: With the bridge idle, a request becomes valid at the fourth rising clock edge after the input line changes.
- R11: A write to the word of line 107 or line 109 updates both lines' words.
- R12: Group codes other than 0 and 1 make the line silent even when it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Asynchronous wired interrupt lines |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| msg_valid | output | 1 | Write request valid |
| msg_ready | input | 1 | Receiver accepts the request |
| msg_addr | output | 64 | Write request address |
| msg_data | output | 32 | Write request data |

## Verification
A line change needs two synchronizer stages, one stage for the edge register and one for the pending bit before the output register loads. The request is therefore due at the fourth rising edge after the change. The bench counts falling edges after its input drive to confirm this exact figure once, when the bridge is idle. Elsewhere it waits at falling edges for the valid flag, with a bounded window. A register write takes effect at the next rising edge. A handshake frees the output at the edge where ready is seen, and the next grant follows one edge later. Checks that something stays silent watch a window several times longer than that four-edge latency.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int CFG_W    = 32;
  localparam int TGT_W    = 64;
  localparam int PAY_W    = 24;
  localparam int EN_BIT   = 24;
  localparam int EDGE_BIT = 28;
  localparam int GRP_LSB  = 29;
  localparam int GRP_W    = 3;

  localparam logic [GRP_W-1:0] GRP_PAIRED = 3'd0;
  localparam logic [GRP_W-1:0] GRP_PULSE  = 3'd1;

  // register byte offsets
  localparam int OFS_PSET_LO = 'h10;
  localparam int OFS_PSET_HI = 'h14;
  localparam int OFS_PCLR_LO = 'h18;
  localparam int OFS_PCLR_HI = 'h1C;
  localparam int OFS_USET_LO = 'h50;
  localparam int OFS_USET_HI = 'h54;
  localparam int OFS_CFG     = 'h100;

  typedef logic [CFG_W-1:0] cfg_t;

  function automatic logic [GRP_W-1:0] cfg_group(cfg_t c);
    return c[GRP_LSB +: GRP_W];
  endfunction

  // line produces any message at all
  function automatic logic cfg_live(cfg_t c);
    return c[EN_BIT] && (cfg_group(c) == GRP_PAIRED || cfg_group(c) == GRP_PULSE);
  endfunction

  // line reports both directions (SET and CLEAR)
  function automatic logic cfg_paired(cfg_t c);
    return c[EN_BIT] && cfg_group(c) == GRP_PAIRED && !c[EDGE_BIT];
  endfunction

  function automatic logic [CFG_W-1:0] cfg_msg_data(cfg_t c);
    return {{(CFG_W-PAY_W){1'b0}}, c[PAY_W-1:0]};
  endfunction
endpackage

// File: rtl/irqm_sync.sv
module irqm_sync #(
  parameter int N = 207
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line_in,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] stg1_q, stg2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1_q <= '0;
      stg2_q <= '0;
      prev_q <= '0;
    end else begin
      stg1_q <= line_in;
      stg2_q <= stg1_q;
      prev_q <= stg2_q;
    end
  end

  assign rise = stg2_q & ~prev_q;
  assign fall = ~stg2_q & prev_q;
endmodule

// File: rtl/irqm_regs.sv
module irqm_regs
  import irqm_pkg::*;
#(
  parameter int N      = 207,
  parameter int AW     = 12,
  parameter int PAIR_A = 107,
  parameter int PAIR_B = 109
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  input  logic [CFG_W-1:0]      wdata,
  output logic [N-1:0][CFG_W-1:0] cfg_q,
  output logic [TGT_W-1:0]      pset_q,
  output logic [TGT_W-1:0]      pclr_q,
  output logic [TGT_W-1:0]      uset_q
);
  int   off;
  int   slot;
  logic slot_hit;

  always_comb begin
    off      = int'(addr);
    slot     = 0;
    slot_hit = 1'b0;
    if (we && off >= OFS_CFG && addr[1:0] == 2'b00) begin
      slot = (off - OFS_CFG) / 4;
      if (slot < N) slot_hit = 1'b1;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_cfg
    localparam bit IN_PAIR = (i == PAIR_A) || (i == PAIR_B);
    logic wr_i;
    assign wr_i = slot_hit &&
                  (slot == i || (IN_PAIR && (slot == PAIR_A || slot == PAIR_B)));
    always_ff @(posedge clk) begin
      if (rst)       cfg_q[i] <= '0;
      else if (wr_i) cfg_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pset_q <= '0;
      pclr_q <= '0;
      uset_q <= '0;
    end else if (we) begin
      case (off)
        OFS_PSET_LO: pset_q[31:0]  <= wdata;
        OFS_PSET_HI: pset_q[63:32] <= wdata;
        OFS_PCLR_LO: pclr_q[31:0]  <= wdata;
        OFS_PCLR_HI: pclr_q[63:32] <= wdata;
        OFS_USET_LO: uset_q[31:0]  <= wdata;
        OFS_USET_HI: uset_q[63:32] <= wdata;
        default: ;
      endcase
    end
  end

  if (PAIR_A < N && PAIR_B < N) begin : g_pair_chk
    // R11: a write to either shared slot leaves both words equal
    a_r11_pair_shared: assert property (@(posedge clk) disable iff (rst)
      slot_hit && (slot == PAIR_A || slot == PAIR_B) |=> cfg_q[PAIR_A] == cfg_q[PAIR_B]);
  end
endmodule

// File: rtl/irqm_pend.sv
module irqm_pend #(
  parameter int N  = 207,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  rise,
  input  logic [N-1:0]  fall,
  input  logic [N-1:0]  live,
  input  logic [N-1:0]  paired,
  input  logic          take,
  input  logic [IW-1:0] take_idx,
  output logic [N-1:0]  req,
  output logic [N-1:0]  want_clr
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic set_q, clr_q, clr_old_q;
    logic set_n, clr_n, clr_old_n;
    logic hit;

    assign hit = take && (take_idx == IW'(i));

    always_comb begin
      set_n     = set_q;
      clr_n     = clr_q;
      clr_old_n = clr_old_q;
      if (hit) begin
        if (want_clr[i]) begin
          clr_n     = 1'b0;
          clr_old_n = 1'b0;
        end else begin
          set_n = 1'b0;
        end
      end
      if (rise[i]) set_n = 1'b1;
      if (fall[i] && paired[i]) begin
        if (!set_n) clr_old_n = 1'b1;
        clr_n = 1'b1;
      end
      if (!paired[i]) begin
        clr_n     = 1'b0;
        clr_old_n = 1'b0;
      end
      if (!live[i]) begin
        set_n     = 1'b0;
        clr_n     = 1'b0;
        clr_old_n = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        set_q     <= 1'b0;
        clr_q     <= 1'b0;
        clr_old_q <= 1'b0;
      end else begin
        set_q     <= set_n;
        clr_q     <= clr_n;
        clr_old_q <= clr_old_n;
      end
    end

    // CLEAR goes first only when it is the older event
    assign want_clr[i] = clr_q && paired[i] && (clr_old_q || !set_q);
    assign req[i]      = live[i] && (set_q || (clr_q && paired[i]));
  end
endmodule

// File: rtl/irqm_rr_arb.sv
module irqm_rr_arb #(
  parameter int N  = 207,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr_q;

  function automatic int wrap_add(int base, int k);
    int s;
    s = base + k;
    if (s >= N) s = s - N;
    return s;
  endfunction

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = wrap_add(int'(ptr_q), k);
      if (!gnt_valid && req[j]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= '0;
    else if (advance) ptr_q <= IW'(wrap_add(int'(gnt_idx), 1));
  end

  // R8: the search start always stays inside the line range
  a_r8_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
    advance |=> int'(ptr_q) < N);
endmodule

// File: rtl/wire_irq_msg_bridge.sv
module wire_irq_msg_bridge
  import irqm_pkg::*;
#(
  parameter int N_LINES = 207,
  parameter int REG_AW  = 12,
  parameter int PAIR_A  = 107,
  parameter int PAIR_B  = 109
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               cfg_we,
  input  logic [REG_AW-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  localparam int IW = $clog2(N_LINES);

  logic [N_LINES-1:0][CFG_W-1:0] cfg_q;
  logic [TGT_W-1:0] pset, pclr, uset;
  logic [N_LINES-1:0] rise, fall, live_v, paired_v, req, want_clr;
  logic               gnt_valid, fire;
  logic [IW-1:0]      gnt_idx;
  cfg_t               sel_cfg;

  irqm_sync #(.N(N_LINES)) u_sync (
    .clk(clk), .rst(rst), .line_in(irq_in), .rise(rise), .fall(fall)
  );

  irqm_regs #(.N(N_LINES), .AW(REG_AW), .PAIR_A(PAIR_A), .PAIR_B(PAIR_B)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cfg_q(cfg_q), .pset_q(pset), .pclr_q(pclr), .uset_q(uset)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_mode
    assign live_v[i]   = cfg_live(cfg_q[i]);
    assign paired_v[i] = cfg_paired(cfg_q[i]);
  end

  irqm_pend #(.N(N_LINES), .IW(IW)) u_pend (
    .clk(clk), .rst(rst), .rise(rise), .fall(fall), .live(live_v),
    .paired(paired_v), .take(fire), .take_idx(gnt_idx),
    .req(req), .want_clr(want_clr)
  );

  irqm_rr_arb #(.N(N_LINES), .IW(IW)) u_arb (
    .clk(clk), .rst(rst), .req(req), .advance(fire),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  assign fire    = gnt_valid && !msg_valid;
  assign sel_cfg = cfg_q[gnt_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (fire) begin
      msg_valid <= 1'b1;
      if (want_clr[gnt_idx])                   msg_addr <= pclr;
      else if (cfg_group(sel_cfg) == GRP_PULSE) msg_addr <= uset;
      else                                     msg_addr <= pset;
      msg_data <= cfg_msg_data(sel_cfg);
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R9: request held unchanged while the receiver stalls
  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R8: a grant is only ever taken for a line with pending work
  a_r8_grant_has_pending: assert property (@(posedge clk) disable iff (rst)
    fire |-> req[gnt_idx]);

  // R7: a disabled line is never served
  a_r7_only_live_lines: assert property (@(posedge clk) disable iff (rst)
    fire |-> live_v[gnt_idx]);

  // R4: CLEAR writes come only from lines that report both directions
  a_r4_clear_paired_only: assert property (@(posedge clk) disable iff (rst)
    fire && want_clr[gnt_idx] |-> paired_v[gnt_idx]);
endmodule

// File: tb/tb_wire_irq_msg_bridge.sv
`timescale 1ns/1ps
module tb_wire_irq_msg_bridge;
  localparam int N = 207;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] lines;
  logic         cfg_we;
  logic [11:0]  cfg_addr;
  logic [31:0]  cfg_wdata;
  logic         msg_valid, msg_ready;
  logic [63:0]  msg_addr;
  logic [31:0]  msg_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [63:0] t_pset, t_pclr, t_uset;

  always #2.5 clk = ~clk;

  wire_irq_msg_bridge dut (
    .clk(clk), .rst(rst), .irq_in(lines), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  function automatic logic [31:0] mk_cfg(bit en, bit edg, logic [2:0] grp, logic [23:0] pay);
    return {grp, edg, 3'b000, en, pay};
  endfunction

  function automatic logic [11:0] cfg_ofs(int n);
    return 12'(256 + 4 * n);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_line(input int i, input bit v);
    @(negedge clk);
    lines[i] = v;
  endtask

  task automatic wait_valid();
    int w = 0;
    while (!msg_valid && w < 40) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic expect_msg(input logic [63:0] ea, input logic [31:0] ed, input string tag);
    wait_valid();
    chk(msg_valid, {tag, " valid"}, 64'(msg_valid), 64'd1);
    if (msg_valid) begin
      chk(msg_addr == ea, {tag, " addr"}, msg_addr, ea);
      chk(msg_data == ed, {tag, " data"}, 64'(msg_data), 64'(ed));
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
    end
  endtask

  task automatic expect_quiet(input int n, input string tag);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (msg_valid) seen = 1;
    end
    chk(!seen, {tag, " quiet"}, 64'(seen), 64'd0);
    if (seen) begin
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [23:0] pay;
    logic [63:0] a0;
    logic [31:0] d0;
    int c;
    void'($urandom(32'h1F2E3D4C));
    rst = 1'b1; lines = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; msg_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: idle after reset, zero word is silent, zero targets
    chk(!msg_valid, "R1 reset valid", 64'(msg_valid), 64'd0);
    set_line(2, 1'b1);
    expect_quiet(12, "R1 zero word line2");
    wr(cfg_ofs(1), mk_cfg(1, 0, 3'd0, 24'h000011));
    set_line(1, 1'b1);
    expect_msg(64'd0, 32'h11, "R1 zero target set");
    set_line(1, 1'b0);
    expect_msg(64'd0, 32'h11, "R1 zero target clear");

    // R3: program targets
    t_pset = {$urandom, $urandom};
    t_pclr = {$urandom, $urandom};
    t_uset = {$urandom, $urandom};
    wr(12'h010, t_pset[31:0]); wr(12'h014, t_pset[63:32]);
    wr(12'h018, t_pclr[31:0]); wr(12'h01C, t_pclr[63:32]);
    wr(12'h050, t_uset[31:0]); wr(12'h054, t_uset[63:32]);

    // R10: latency of four rising edges, R2 payload, R4 set/clear
    wr(cfg_ofs(3), mk_cfg(1, 0, 3'd0, 24'hA5B6C7));
    set_line(3, 1'b1);
    c = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (msg_valid && c == 0) c = k;
    end
    chk(c == 4, "R10 latency", 64'(c), 64'd4);
    expect_msg(t_pset, 32'h00A5B6C7, "R3 R4 set");
    set_line(3, 1'b0);
    expect_msg(t_pclr, 32'h00A5B6C7, "R4 clear");

    // R5: pulse group and paired group with edge flag
    wr(cfg_ofs(4), mk_cfg(1, 1, 3'd1, 24'h000444));
    set_line(4, 1'b1);
    expect_msg(t_uset, 32'h444, "R5 pulse set");
    set_line(4, 1'b0);
    expect_quiet(12, "R5 pulse fall");
    wr(cfg_ofs(5), mk_cfg(1, 1, 3'd0, 24'h000555));
    set_line(5, 1'b1);
    expect_msg(t_pset, 32'h555, "R5 edge flag set");
    set_line(5, 1'b0);
    expect_quiet(12, "R5 edge flag fall");

    // R12: unused group code
    wr(cfg_ofs(6), mk_cfg(1, 0, 3'd2, 24'h000666));
    set_line(6, 1'b1);
    expect_quiet(12, "R12 group2 rise");
    set_line(6, 1'b0);
    expect_quiet(12, "R12 group2 fall");

    // R11: shared configuration of 107 and 109
    wr(cfg_ofs(107), mk_cfg(1, 0, 3'd0, 24'h107107));
    set_line(109, 1'b1);
    expect_msg(t_pset, 32'h00107107, "R11 via107 set");
    set_line(109, 1'b0);
    expect_msg(t_pclr, 32'h00107107, "R11 via107 clear");
    wr(cfg_ofs(109), mk_cfg(1, 0, 3'd1, 24'h109109));
    set_line(107, 1'b1);
    expect_msg(t_uset, 32'h00109109, "R11 via109 set");
    set_line(107, 1'b0);
    expect_quiet(12, "R11 via109 fall");

    // R9: stalled request stays stable
    wr(cfg_ofs(8), mk_cfg(1, 0, 3'd0, 24'h000888));
    set_line(8, 1'b1);
    wait_valid();
    a0 = msg_addr; d0 = msg_data;
    c = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (!msg_valid || msg_addr != a0 || msg_data != d0) c++;
    end
    chk(c == 0, "R9 hold", 64'(c), 64'd0);
    expect_msg(t_pset, 32'h888, "R9 accept");
    set_line(8, 1'b0);
    expect_msg(t_pclr, 32'h888, "R9 clear");

    // R6: short pulse while blocked keeps SET then CLEAR
    wr(cfg_ofs(30), mk_cfg(1, 0, 3'd0, 24'h000030));
    wr(cfg_ofs(20), mk_cfg(1, 0, 3'd0, 24'h000020));
    set_line(30, 1'b1);
    wait_valid();
    set_line(20, 1'b1);
    repeat (3) @(negedge clk);
    lines[20] = 1'b0;
    repeat (6) @(negedge clk);
    expect_msg(t_pset, 32'h30, "R6 blocker");
    expect_msg(t_pset, 32'h20, "R6 set first");
    expect_msg(t_pclr, 32'h20, "R6 clear second");

    // R7: disable drops pending work
    wr(cfg_ofs(31), mk_cfg(1, 0, 3'd0, 24'h000031));
    wr(cfg_ofs(40), mk_cfg(1, 0, 3'd0, 24'h000040));
    set_line(31, 1'b1);
    wait_valid();
    set_line(40, 1'b1);
    repeat (6) @(negedge clk);
    wr(cfg_ofs(40), 32'h0);
    repeat (2) @(negedge clk);
    expect_msg(t_pset, 32'h31, "R7 presented kept");
    expect_quiet(20, "R7 dropped");
    set_line(40, 1'b0);
    expect_quiet(12, "R7 disabled fall");

    // R8: round-robin order
    wr(cfg_ofs(10), mk_cfg(1, 0, 3'd0, 24'h000010));
    wr(cfg_ofs(12), mk_cfg(1, 0, 3'd0, 24'h000012));
    set_line(10, 1'b1);
    expect_msg(t_pset, 32'h10, "R8 prime");
    @(negedge clk);
    lines[3] = 1'b1; lines[12] = 1'b1;
    expect_msg(t_pset, 32'h12, "R8 first after ptr");
    expect_msg(t_pset, 32'hA5B6C7, "R8 wrapped second");
    @(negedge clk);
    lines[3] = 1'b0; lines[12] = 1'b0;
    expect_msg(t_pclr, 32'h12, "R8 clear first");
    expect_msg(t_pclr, 32'hA5B6C7, "R8 clear second");

    // random single transitions checked against the mode rules (R4 R5 R2)
    for (int it = 0; it < 60; it++) begin
      int i, md;
      bit nv;
      i = 50 + int'($urandom % 150);
      if (i == 107 || i == 109) i = 110;
      md = int'($urandom % 3);
      pay = 24'($urandom);
      if (md == 0)      wr(cfg_ofs(i), mk_cfg(1, 0, 3'd0, pay));
      else if (md == 1) wr(cfg_ofs(i), mk_cfg(1, 0, 3'd1, pay));
      else              wr(cfg_ofs(i), mk_cfg(1, 1, 3'd0, pay));
      nv = !lines[i];
      set_line(i, nv);
      if (nv)           expect_msg(md == 1 ? t_uset : t_pset, {8'h0, pay}, "R5 R4 random rise");
      else if (md == 0) expect_msg(t_pclr, {8'h0, pay}, "R4 random fall");
      else              expect_quiet(12, "R5 random fall");
    end

    done = 1;
    report();
  end
endmodule